// File: doc/BRIEF.md
# Translated DMA Channel

This block is one device DMA channel. It moves a burst of bytes between a device-side data path and system memory. The device names memory through logical addresses. These pass through a single-level translation table that sits in memory. Software programs three channel registers: control, byte count and logical start address. A table base and a table limit are shared by all channels and arrive as inputs.

A device asks for a burst with a request handshake. The request carries a direction and a length. The channel first checks the request against its control register. It clamps the length to the programmed count. It then walks the logical range one 4 KiB page at a time. On entering each page it reads that page's table entry, then moves the page's bytes with 32-bit word accesses on a valid/ready memory port. Byte enables cover partial words at the head and tail.

On completion the count is reduced by the bytes moved and a terminal-count flag is set. A rejected request sets a memory-error flag and the channel's error output, and moves nothing.

Top module: `ptdma_channel`

## Requirements
- R1: After reset the control, count and start-address registers read zero, and `busy`, `chan_err` and `mem_valid` are low.
- R2: A request is rejected when control bit 0 (enable) is 0, or when `req_to_dev` differs from control bit 1 (1 = memory to device). A rejected request sets control bit 9 and `chan_err`, issues no memory access, and leaves the count unchanged.
- R3: Every accepted request clears control bits 8, 9 and 10 before any other flag update.
- R4: Each page fetch is a full-word read (`mem_be` = 4'b1111) at the table base plus page index (address bits 31:12) times 8, with bit 31 forced to 0. The first word of the entry is the physical frame base.
- R5: A data access targets the word holding the frame base plus the page offset (address bits 11:0). `mem_be` bit k selects byte lane k, which is address bits 1:0 equal to k. The enables cover the bytes from the start lane up to the lesser of the word end and the bytes left.
- R6: No access crosses a 4096-byte logical page. After a page is used up, the next page's entry is fetched before its data.
- R7: If the page index is at or above the table limit divided by 8, the transfer ends there with no further memory access. It still sets bit 8 and reduces the count by the bytes already moved.
- R8: The length moved is the smaller of `req_len` and the count register. On completion the count drops by that amount and control bit 8 is set. A zero length completes at once with no memory access.
- R9: In memory-to-device mode each read word appears on `dev_rdata` with `dev_be` during the `dev_strobe` cycle. In device-to-memory mode `mem_wdata` carries `dev_wdata`, and `dev_strobe` marks the word taken. Table fetches do not pulse `dev_strobe`.
- R10: `busy` is high from the cycle after a non-empty request is accepted until the final word completes. `req_ready` is low while busy. Register writes made while busy are ignored.
- R11: Once `mem_valid` is raised, it and `mem_addr`, `mem_be` and `mem_we` hold until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 start address |
| cfg_wdata | input | 32 | Register write data |
| tbl_base | input | 32 | Shared translation table base |
| tbl_limit | input | 32 | Shared translation table limit in bytes |
| req_valid | input | 1 | Device transfer request |
| req_to_dev | input | 1 | Requested direction, 1 = memory to device |
| req_len | input | LEN_W | Requested byte count |
| req_ready | output | 1 | Channel idle and able to accept |
| busy | output | 1 | Transfer in progress |
| ctrl_q | output | 32 | Control register with flags |
| count_q | output | 32 | Count register |
| start_q | output | 32 | Logical start address register |
| chan_err | output | 1 | Sticky channel error |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts request; read data valid |
| mem_rdata | input | 32 | Memory read data |
| dev_wdata | input | 32 | Device data for device-to-memory mode |
| dev_rdata | output | 32 | Data to the device in memory-to-device mode |
| dev_be | output | 4 | Valid byte lanes of the current data word |
| dev_strobe | output | 1 | Data word moved this cycle |

## Verification
The hardest case to reach is an early stop at the table limit after some data has already moved. The table must accept the first page, the burst must run past a page edge, and the second index must land exactly on the limit. The stimulus starts four bytes below a page boundary, with the limit set to three entries and the start in page two. This makes one word move before the fetch for page three is refused. A second hard case is a register write landing mid-burst. The memory model stretches each handshake by several cycles, so a count write can be driven while `busy` is known to be high.

// File: rtl/ptdma_pkg.sv
package ptdma_pkg;
  localparam int WORD_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int IDX_W     = WORD_W - PAGE_BITS;
  localparam int ENT_SHIFT = 3;   // 8-byte table entries

  localparam int CTL_EN    = 0;
  localparam int CTL_TODEV = 1;
  localparam int CTL_TC    = 8;
  localparam int CTL_MERR  = 9;
  localparam int CTL_AERR  = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} ptdma_state_e;

  // table entry location, top bit dropped
  function automatic logic [WORD_W-1:0] entry_addr(input logic [WORD_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] a;
    a = base + ({{(WORD_W-IDX_W){1'b0}}, idx} << ENT_SHIFT);
    a[WORD_W-1] = 1'b0;
    return a;
  endfunction

  function automatic logic limit_hit(input logic [IDX_W-1:0] idx,
                                     input logic [WORD_W-1:0] limit);
    return {{(WORD_W-IDX_W){1'b0}}, idx} >= (limit >> ENT_SHIFT);
  endfunction

  // bytes in this access: bounded by word end, bytes left and page end
  function automatic logic [2:0] chunk_len(input logic [1:0] lane,
                                           input logic [PAGE_BITS-1:0] off,
                                           input logic [WORD_W-1:0] rem);
    logic [WORD_W-1:0] n;
    logic [WORD_W-1:0] room;
    n = WORD_W'(4) - WORD_W'(lane);
    if (rem < n) n = rem;
    room = WORD_W'(PAGE_SIZE) - WORD_W'(off);
    if (room < n) n = room;
    return n[2:0];
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lane, input logic [2:0] n);
    logic [4:0] ones;
    ones = (5'd1 << n) - 5'd1;
    return ones[3:0] << lane;
  endfunction
endpackage

// File: rtl/ptdma_xlate.sv
module ptdma_xlate
  import ptdma_pkg::*;
(
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [WORD_W-1:0] tbl_base,
  input  logic [WORD_W-1:0] tbl_limit,
  input  logic [WORD_W-1:0] frame,
  input  logic [WORD_W-1:0] remaining,
  output logic [WORD_W-1:0] ent_addr,
  output logic [WORD_W-1:0] word_addr,
  output logic              over_limit,
  output logic [3:0]        lane_be,
  output logic [2:0]        nbytes,
  output logic              page_end
);
  logic [IDX_W-1:0]     idx;
  logic [PAGE_BITS-1:0] off;
  logic [WORD_W-1:0]    ent;
  logic [WORD_W-1:0]    phys;
  logic [PAGE_BITS:0]   off_next;

  assign idx        = cur_addr[WORD_W-1:PAGE_BITS];
  assign off        = cur_addr[PAGE_BITS-1:0];
  assign ent        = entry_addr(tbl_base, idx);
  assign ent_addr   = {ent[WORD_W-1:2], 2'b00};
  assign over_limit = limit_hit(idx, tbl_limit);
  assign phys       = frame + {{IDX_W{1'b0}}, off};
  assign nbytes     = chunk_len(phys[1:0], off, remaining);
  assign lane_be    = lane_mask(phys[1:0], nbytes);
  assign word_addr  = {phys[WORD_W-1:2], 2'b00};
  assign off_next   = {1'b0, off} + {{(PAGE_BITS-2){1'b0}}, nbytes};
  assign page_end   = off_next[PAGE_BITS];
endmodule

// File: rtl/ptdma_engine.sv
module ptdma_engine
  import ptdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_to_dev,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WORD_W-1:0] ctrl,
  input  logic [WORD_W-1:0] count,
  input  logic [WORD_W-1:0] start_addr,
  input  logic [WORD_W-1:0] tbl_base,
  input  logic [WORD_W-1:0] tbl_limit,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] dev_wdata,
  output logic              req_ready,
  output logic              busy,
  output logic              ev_accept,
  output logic              ev_reject,
  output logic              ev_fin,
  output logic [WORD_W-1:0] fin_bytes,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] dev_rdata,
  output logic [3:0]        dev_be,
  output logic              dev_strobe
);
  ptdma_state_e      state_q;
  logic [WORD_W-1:0] cur_q, rem_q, moved_q, frame_q;
  logic              todev_q;

  logic [WORD_W-1:0] ent_addr, word_addr, len_ext, clamp;
  logic              over_limit, page_end;
  logic [3:0]        lane_be;
  logic [2:0]        nbytes;
  logic              bad_req, ev_start, ev_empty, hs;
  logic              ev_fetch_done, ev_stop_limit, ev_word_done, ev_last;

  ptdma_xlate u_xlate (
    .cur_addr  (cur_q),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .frame     (frame_q),
    .remaining (rem_q),
    .ent_addr  (ent_addr),
    .word_addr (word_addr),
    .over_limit(over_limit),
    .lane_be   (lane_be),
    .nbytes    (nbytes),
    .page_end  (page_end)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign len_ext   = WORD_W'(req_len);
  assign clamp     = (len_ext > count) ? count : len_ext;

  assign bad_req   = !ctrl[CTL_EN] || (req_to_dev != ctrl[CTL_TODEV]);
  assign ev_accept = req_valid && req_ready;
  assign ev_reject = ev_accept && bad_req;
  assign ev_start  = ev_accept && !bad_req;
  assign ev_empty  = ev_start && (clamp == '0);

  assign mem_valid = (state_q == ST_XFER) || ((state_q == ST_FETCH) && !over_limit);
  assign mem_we    = (state_q == ST_XFER) && !todev_q;
  assign mem_addr  = (state_q == ST_FETCH) ? ent_addr : word_addr;
  assign mem_be    = (state_q == ST_FETCH) ? 4'hF : lane_be;
  assign mem_wdata = dev_wdata;
  assign hs        = mem_valid && mem_ready;

  assign ev_fetch_done = (state_q == ST_FETCH) && hs;
  assign ev_stop_limit = (state_q == ST_FETCH) && over_limit;
  assign ev_word_done  = (state_q == ST_XFER) && hs;
  assign ev_last       = ev_word_done && (rem_q == WORD_W'(nbytes));
  assign ev_fin        = ev_empty || ev_stop_limit || ev_last;

  always_comb begin
    fin_bytes = '0;
    if (ev_last)            fin_bytes = moved_q + WORD_W'(nbytes);
    else if (ev_stop_limit) fin_bytes = moved_q;
  end

  assign dev_strobe = ev_word_done;
  assign dev_be     = lane_be;
  assign dev_rdata  = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      moved_q <= '0;
      frame_q <= '0;
      todev_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ev_start && !ev_empty) begin
          cur_q   <= start_addr;
          rem_q   <= clamp;
          moved_q <= '0;
          todev_q <= req_to_dev;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (ev_stop_limit) state_q <= ST_IDLE;
          else if (ev_fetch_done) begin
            frame_q <= mem_rdata;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: if (ev_word_done) begin
          cur_q   <= cur_q + WORD_W'(nbytes);
          rem_q   <= rem_q - WORD_W'(nbytes);
          moved_q <= moved_q + WORD_W'(nbytes);
          if (ev_last)       state_q <= ST_IDLE;
          else if (page_end) state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptdma_regs.sv
module ptdma_regs
  import ptdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              ev_accept,
  input  logic              ev_reject,
  input  logic              ev_fin,
  input  logic [WORD_W-1:0] fin_bytes,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] count_q,
  output logic [WORD_W-1:0] start_q,
  output logic              err_q
);
  logic [WORD_W-1:0] ctrl_n, count_n, start_n;
  logic              err_n;
  logic              wr_ok;

  assign wr_ok = cfg_we && !busy && !ev_accept;

  always_comb begin
    ctrl_n  = ctrl_q;
    count_n = count_q;
    start_n = start_q;
    err_n   = err_q;
    if (wr_ok) begin
      unique case (cfg_sel)
        2'd0:    ctrl_n  = cfg_wdata;
        2'd1:    count_n = cfg_wdata;
        2'd2:    start_n = cfg_wdata;
        default: ;
      endcase
    end
    if (ev_accept) begin
      ctrl_n[CTL_TC]   = 1'b0;
      ctrl_n[CTL_MERR] = 1'b0;
      ctrl_n[CTL_AERR] = 1'b0;
    end
    if (ev_reject) begin
      ctrl_n[CTL_MERR] = 1'b1;
      err_n            = 1'b1;
    end
    if (ev_fin) begin
      ctrl_n[CTL_TC] = 1'b1;
      count_n        = count_n - fin_bytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
      start_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      count_q <= count_n;
      start_q <= start_n;
      err_q   <= err_n;
    end
  end
endmodule

// File: rtl/ptdma_channel.sv
module ptdma_channel
  import ptdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [31:0]      tbl_base,
  input  logic [31:0]      tbl_limit,
  input  logic             req_valid,
  input  logic             req_to_dev,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             busy,
  output logic [31:0]      ctrl_q,
  output logic [31:0]      count_q,
  output logic [31:0]      start_q,
  output logic             chan_err,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      dev_wdata,
  output logic [31:0]      dev_rdata,
  output logic [3:0]       dev_be,
  output logic             dev_strobe
);
  logic              ev_accept, ev_reject, ev_fin;
  logic [WORD_W-1:0] fin_bytes;

  ptdma_engine #(.LEN_W(LEN_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_to_dev(req_to_dev),
    .req_len   (req_len),
    .ctrl      (ctrl_q),
    .count     (count_q),
    .start_addr(start_q),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .dev_wdata (dev_wdata),
    .req_ready (req_ready),
    .busy      (busy),
    .ev_accept (ev_accept),
    .ev_reject (ev_reject),
    .ev_fin    (ev_fin),
    .fin_bytes (fin_bytes),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .dev_rdata (dev_rdata),
    .dev_be    (dev_be),
    .dev_strobe(dev_strobe)
  );

  ptdma_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy     (busy),
    .ev_accept(ev_accept),
    .ev_reject(ev_reject),
    .ev_fin   (ev_fin),
    .fin_bytes(fin_bytes),
    .ctrl_q   (ctrl_q),
    .count_q  (count_q),
    .start_q  (start_q),
    .err_q    (chan_err)
  );
endmodule

// File: rtl/ptdma_checker.sv
module ptdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic        cfg_we,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] ctrl_q,
  input logic [31:0] count_q,
  input logic [31:0] start_q,
  input logic        chan_err,
  input logic        ev_reject,
  input logic        ev_fin
);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we));
  // R2
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> ctrl_q[9] && chan_err && !busy);
  // R8
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fin |=> ctrl_q[8] && !busy);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));
  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we && !ev_fin |=> $stable(count_q) && $stable(start_q));
  // R5
  lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $countones(mem_be) != 0);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
endmodule

bind ptdma_channel ptdma_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .cfg_we   (cfg_we),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .ctrl_q   (ctrl_q),
  .count_q  (count_q),
  .start_q  (start_q),
  .chan_err (chan_err),
  .ev_reject(ev_reject),
  .ev_fin   (ev_fin)
);

// File: tb/sim_ptdma_channel.sv
`timescale 1ns/1ps
module sim_ptdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] tbl_base = '0, tbl_limit = '0;
  logic        req_valid = 1'b0, req_to_dev = 1'b0;
  logic [15:0] req_len = '0;
  logic        req_ready, busy, chan_err;
  logic [31:0] ctrl_q, count_q, start_q;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] dev_wdata = 32'hA500_0000;
  logic [31:0] dev_rdata;
  logic [3:0]  dev_be;
  logic        dev_strobe;

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, wait_c = 0, dw_k = 0;
  logic last_we = 1'b0;
  logic [31:0] frame_ofs = '0;

  logic [31:0] lg_addr [64];
  logic [3:0]  lg_be   [64];
  logic        lg_we   [64];
  logic [31:0] lg_wd   [64];
  logic        lg_stb  [64];
  logic [31:0] lg_drd  [64];
  logic [3:0]  lg_dbe  [64];
  int          lg_n = 0;

  logic [31:0] ex_addr [64];
  logic [3:0]  ex_be   [64];
  logic        ex_we   [64];
  logic [31:0] ex_wd   [64];
  logic        ex_dat  [64];
  int          ex_n = 0;

  always #2.5 clk = ~clk;

  ptdma_channel #(.LEN_W(16)) u0 (.*);

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return 32'h0004_0000 + ({19'd0, a[15:3]} << 12) + frame_ofs;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ready after lat wait cycles, logs each access
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wait_c = lat;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      wait_c = lat;
      if (last_we) begin
        dw_k++;
        dev_wdata = 32'hA500_0000 + dw_k;
      end
    end else if (mem_valid) begin
      if (wait_c > 0) wait_c--;
      else begin
        last_we = mem_we;
        mem_rdata = mem_fn(mem_addr);
        if (lg_n < 64) begin
          lg_addr[lg_n] = mem_addr; lg_be[lg_n] = mem_be;
          lg_we[lg_n] = mem_we;     lg_wd[lg_n] = mem_wdata;
        end
        mem_ready = 1'b1;
        #1;
        if (lg_n < 64) begin
          lg_stb[lg_n] = dev_strobe; lg_drd[lg_n] = dev_rdata; lg_dbe[lg_n] = dev_be;
        end
        lg_n++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request(input logic todev, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_to_dev = todev; req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl_q == 0, ctrl_q, 0);
    check("R1 count", count_q == 0, count_q, 0);
    check("R1 start", start_q == 0, start_q, 0);
    check("R1 flags", !busy && !chan_err && !mem_valid, {29'd0, busy, chan_err, mem_valid}, 0);
  endtask

  // R2 / R3: rejection leaves count and memory alone
  task automatic t_reject(input string tag, input logic [31:0] ctl, input logic todev);
    cfg_write(2'd1, 32'd100);
    cfg_write(2'd0, ctl);
    lg_n = 0;
    request(todev, 12);
    wait_idle();
    check({tag, " ctrl"}, ctrl_q == ((ctl & ~32'h700) | 32'h200), ctrl_q, (ctl & ~32'h700) | 32'h200);
    check({tag, " err"}, chan_err == 1'b1, {31'd0, chan_err}, 1);
    check({tag, " count"}, count_q == 100, count_q, 100);
    check({tag, " no access"}, lg_n == 0, lg_n, 0);
  endtask

  task automatic run_xfer(input string tag, input logic [31:0] st, input int len,
                          input logic [31:0] cnt, input logic todev, input logic [31:0] base,
                          input logic [31:0] lim, input logic [31:0] fofs, input int l,
                          input bit poke);
    logic [31:0] ctl, la, fr, ph, ent, moved, eff;
    int rem, n, k;
    bit need;
    tbl_base = base; tbl_limit = lim; frame_ofs = fofs; lat = l;
    ctl = 32'h400 | {30'd0, todev, 1'b1};
    cfg_write(2'd0, ctl);
    cfg_write(2'd1, cnt);
    cfg_write(2'd2, st);
    // expected access list
    eff = (32'(len) > cnt) ? cnt : 32'(len);
    ex_n = 0; moved = 0; la = st; rem = int'(eff); need = 1; k = 0; fr = 0;
    while (rem > 0) begin
      if (need) begin
        if ({12'd0, la[31:12]} >= (lim >> 3)) break;
        ent = (base + {la[31:12], 3'b000}) & 32'h7FFF_FFFF;
        ex_addr[ex_n] = ent & ~32'h3; ex_be[ex_n] = 4'hF; ex_we[ex_n] = 1'b0;
        ex_wd[ex_n] = '0; ex_dat[ex_n] = 1'b0; ex_n++;
        fr = mem_fn(ent & ~32'h3);
        need = 0;
      end
      ph = fr + {20'd0, la[11:0]};
      n = 4 - int'(ph[1:0]);
      if (n > rem) n = rem;
      if (n > 4096 - int'(la[11:0])) n = 4096 - int'(la[11:0]);
      ex_addr[ex_n] = ph & ~32'h3;
      ex_be[ex_n] = 4'(((1 << n) - 1) << ph[1:0]);
      ex_we[ex_n] = !todev; ex_dat[ex_n] = 1'b1;
      ex_wd[ex_n] = 32'hA500_0000 + 32'(k);
      if (!todev) k++;
      ex_n++;
      la = la + 32'(n); rem = rem - n; moved = moved + 32'(n);
      if (la[11:0] == 0) need = 1;
    end
    lg_n = 0; dw_k = 0; dev_wdata = 32'hA500_0000;
    request(todev, len);
    if (poke) begin
      check({tag, " busy"}, busy && !req_ready, {30'd0, busy, req_ready}, 2);
      cfg_write(2'd1, 32'd999);
      cfg_write(2'd2, 32'h0BAD_0000);
    end
    wait_idle();
    check({tag, " access count"}, lg_n == ex_n, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n && i < 64; i++) begin
      check({tag, " addr"}, lg_addr[i] == ex_addr[i], lg_addr[i], ex_addr[i]);
      check({tag, " be/we/strobe"},
            lg_be[i] == ex_be[i] && lg_we[i] == ex_we[i] && lg_stb[i] == ex_dat[i],
            {lg_be[i], 3'd0, lg_we[i], 3'd0, lg_stb[i]}, {ex_be[i], 3'd0, ex_we[i], 3'd0, ex_dat[i]});
      if (ex_dat[i] && ex_we[i])
        check({tag, " R9 wdata"}, lg_wd[i] == ex_wd[i], lg_wd[i], ex_wd[i]);
      if (ex_dat[i] && !ex_we[i])
        check({tag, " R9 dev data"}, lg_drd[i] == mem_fn(ex_addr[i]) && lg_dbe[i] == ex_be[i],
              lg_drd[i], mem_fn(ex_addr[i]));
    end
    check({tag, " count"}, count_q == cnt - moved, count_q, cnt - moved);
    check({tag, " R3 ctrl"}, ctrl_q == ((ctl & ~32'h700) | 32'h100), ctrl_q, (ctl & ~32'h700) | 32'h100);
    check({tag, " start kept"}, start_q == st, start_q, st);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject("R2 disabled", 32'h0000_0500, 1'b0);
    t_reject("R2 direction R3", 32'h0000_0701, 1'b1);
    run_xfer("R4 R5 R9 aligned read", 32'h0000_3000, 16, 100, 1'b1, 32'h0000_0100, 32'h0001_0000, 0, 0, 0);
    run_xfer("R5 R9 unaligned write", 32'h0000_1003, 9, 100, 1'b0, 32'h0000_0100, 32'h0001_0000, 0, 1, 0);
    run_xfer("R5 unaligned frame", 32'h0000_0000, 8, 50, 1'b1, 32'h0000_0100, 32'h0001_0000, 2, 0, 0);
    run_xfer("R6 page cross", 32'h0000_1FFA, 12, 64, 1'b0, 32'h0000_0200, 32'h0001_0000, 0, 0, 0);
    run_xfer("R8 clamp", 32'h0000_4001, 20, 5, 1'b1, 32'h0000_0100, 32'h0001_0000, 0, 0, 0);
    run_xfer("R7 limit stop", 32'h0000_2FFC, 16, 100, 1'b1, 32'h0000_0100, 32'd24, 0, 2, 0);
    run_xfer("R4 top bit", 32'h0000_5000, 4, 10, 1'b0, 32'h8000_1000, 32'h0001_0000, 0, 0, 0);
    run_xfer("R8 zero count", 32'h0000_6000, 8, 0, 1'b1, 32'h0000_0100, 32'h0001_0000, 0, 0, 0);
    run_xfer("R10 R11 busy lock", 32'h0000_7000, 32, 200, 1'b0, 32'h0000_0100, 32'h0001_0000, 0, 3, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule